// File: doc/BRIEF.md
# Sleep and Nap Power Controller

This block sequences the power states of a multi-channel data converter. It has two low-power states. In deep sleep the whole device is off, including the shared reference and clock-synthesis domain. In nap, only the channels chosen by a mask are turned off, and the shared domain keeps running. The block drives a power-down enable for the shared domain and one for each channel. It also raises a per-channel ready flag once the required recovery time has passed after waking.

Recovery from nap is counted in sample-clock cycles. When the optional accurate-settling request is set, an extra wait counted in microseconds follows. Recovery from deep sleep is counted only in microseconds. A programmable prescaler divides the sample clock down to a one-microsecond tick. If a new request arrives during a recovery, the wake-up is abandoned and the affected domain goes back to its low-power state. The next wake-up then starts its count from zero.

Top module: `pwr_sleep_nap_ctrl`

## Requirements
- R1: One clock edge after a sleep request is sampled, `ref_pd_o` is 1.
- R2: A sleep request is the OR of `sleep_bit_i` and the term (`par_mode_i` AND `sleep_pin_i`). While `par_mode_i` is 0, `sleep_pin_i` has no effect on any output.
- R3: One edge after a channel's bit in `nap_mask_i` is sampled high, that channel's `ch_pd_o` bit is 1. Other channels and `ref_pd_o` are unaffected.
- R4: One edge after the mask bit is sampled low, the channel's `ch_pd_o` bit falls. Its `ch_ready_o` bit rises exactly NAP_CYC (default 100) edges after that.
- R5: If `settle_req_i` is 1 at the end of the cycle count, `ch_ready_o` rises only after a further SETTLE_US (default 50) microsecond ticks.
- R6: A microsecond tick occurs every `tick_div_i` clock cycles. A value of 0 behaves as 1.
- R7: After a sleep request is released, `ref_ready_o` rises after `sleep_us_i` ticks. A value of 0 selects DEF_SLEEP_US (default 2000) ticks.
- R8: While `ref_pd_o` is 1, every `ch_pd_o` bit is 1 and every `ch_ready_o` bit is 0, whatever the nap mask holds.
- R9: A new request during a recovery puts the domain back into its low-power state on the next edge. The following recovery then waits its full time again.
- R10: After reset, nothing is powered down and all ready flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_bit_i | input | 1 | Sleep request from the mode register |
| par_mode_i | input | 1 | 1 when the static-pin programming mode is selected |
| sleep_pin_i | input | 1 | Static sleep pin, used only when `par_mode_i` is 1 |
| nap_mask_i | input | NCH | Per-channel nap request |
| settle_req_i | input | 1 | Add the accurate-settling delay after nap |
| tick_div_i | input | DW | Clock cycles per microsecond |
| sleep_us_i | input | SW | Sleep recovery time in microseconds (0 selects the default) |
| ref_pd_o | output | 1 | Shared reference/clock domain powered down |
| ch_pd_o | output | NCH | Per-channel power-down |
| ch_ready_o | output | NCH | Per-channel ready |
| ref_ready_o | output | 1 | Shared domain recovered and ready |

## Verification
The inline assertions check on every cycle that a request produces a power-down on the next edge. They also check that a sleeping shared domain forces every channel off and clears its ready flag, that a recovering channel never reports ready early, and that ticks never arrive back to back. The exact recovery lengths can only be shown by the bench's timed scenarios: the 100-cycle nap count, the extra settling wait, the programmed and default sleep times, and the restart after an aborted wake-up. The same applies to the pin being ignored outside static-pin mode.

// File: rtl/pwrseq_pkg.sv
// Shared state encodings for the power-state sequencer.
// Assumes: nothing beyond a single clock domain.
package pwrseq_pkg;
    // Shared reference/clock domain state
    typedef enum logic [1:0] {
        DOM_AWAKE   = 2'd0,
        DOM_ASLEEP  = 2'd1,
        DOM_RECOVER = 2'd2
    } dom_state_t;

    // Per-channel state
    typedef enum logic [1:0] {
        CH_RUN  = 2'd0,
        CH_NAP  = 2'd1,
        CH_WCYC = 2'd2,
        CH_WUS  = 2'd3
    } ch_state_t;
endpackage

// File: rtl/pwrseq_tick.sv
// Microsecond tick generator: a one-cycle pulse every div_i clock cycles.
// Assumes: div_i is held steady between programmings; 0 is treated as 1.
module pwrseq_tick #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div_i,
    output logic          tick_o
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] lim;

    // Effective divide ratio, with zero mapped to one
    always_comb lim = (div_i == '0) ? DW'(1) : div_i;

    // Free-running divider that pulses the tick at the wrap point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt >= lim - DW'(1)) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + DW'(1);
            tick_o <= 1'b0;
        end
    end

    // R6: with a ratio above one, two ticks never arrive on consecutive cycles
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim > DW'(1) && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/pwrseq_ref.sv
// Shared reference/clock domain sequencer for deep sleep.
// Powers the domain down while a request is held. On release it waits a
// programmed number of microsecond ticks before it reports ready.
// Assumes: tick_i is a single-cycle pulse; us_i == 0 selects DEF_US.
module pwrseq_ref
    import pwrseq_pkg::*;
#(
    parameter int SW     = 16,
    parameter int DEF_US = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          tick_i,
    input  logic [SW-1:0] us_i,
    output logic          pd_o,
    output logic          ready_o
);
    dom_state_t    st;
    logic [SW-1:0] cnt;
    logic [SW-1:0] target;

    // Recovery length in ticks, with zero selecting the default
    always_comb target = (us_i == '0) ? SW'(DEF_US) : us_i;

    // Sleep / recover / awake state machine with its tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= DOM_AWAKE;
            cnt <= '0;
        end else begin
            case (st)
                DOM_AWAKE: begin
                    if (req_i) st <= DOM_ASLEEP;
                end
                DOM_ASLEEP: begin
                    if (!req_i) begin
                        st  <= DOM_RECOVER;
                        cnt <= '0;
                    end
                end
                DOM_RECOVER: begin
                    if (req_i) begin
                        st <= DOM_ASLEEP;
                    end else if (tick_i) begin
                        if (cnt >= target - SW'(1)) st <= DOM_AWAKE;
                        else                        cnt <= cnt + SW'(1);
                    end
                end
                default: st <= DOM_AWAKE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        pd_o    = (st == DOM_ASLEEP);
        ready_o = (st == DOM_AWAKE);
    end

    // R1 / R9: any sampled request powers the domain down on the next edge
    assert_sleep_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pd_o);
    // R7: the recovery only completes on a tick
    assert_recover_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && $past(rst_n)) |-> $past(tick_i));
    // R9: a request while recovering never lets ready through
    assert_abort_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DOM_RECOVER && req_i) |=> !ready_o);
endmodule

// File: rtl/pwrseq_chan.sv
// Per-channel nap sequencer.
// Powers the channel down while its nap bit is set. On release it counts
// NAP_CYC clock cycles, then optionally SETTLE_US microsecond ticks.
// Assumes: hold_i is high while the shared domain sleeps; counting pauses then.
module pwrseq_chan
    import pwrseq_pkg::*;
#(
    parameter int NAP_CYC   = 100,
    parameter int SETTLE_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nap_i,
    input  logic hold_i,
    input  logic settle_i,
    input  logic tick_i,
    input  logic ref_ready_i,
    output logic pd_o,
    output logic ready_o
);
    localparam int CW = $clog2(NAP_CYC + 1);
    localparam int UW = $clog2(SETTLE_US + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(NAP_CYC - 1);
    localparam logic [UW-1:0] US_LAST  = UW'(SETTLE_US - 1);

    ch_state_t     st;
    logic [CW-1:0] cyc;
    logic [UW-1:0] us;

    // Nap / cycle-wait / settle-wait / run state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CH_RUN;
            cyc <= '0;
            us  <= '0;
        end else if (nap_i) begin
            st <= CH_NAP;
        end else begin
            case (st)
                CH_RUN: st <= CH_RUN;
                CH_NAP: begin
                    st  <= CH_WCYC;
                    cyc <= '0;
                end
                CH_WCYC: begin
                    if (!hold_i) begin
                        if (cyc == CYC_LAST) begin
                            us <= '0;
                            st <= settle_i ? CH_WUS : CH_RUN;
                        end else begin
                            cyc <= cyc + CW'(1);
                        end
                    end
                end
                CH_WUS: begin
                    if (!hold_i && tick_i) begin
                        if (us == US_LAST) st <= CH_RUN;
                        else               us <= us + UW'(1);
                    end
                end
                default: st <= CH_RUN;
            endcase
        end
    end

    // Output decode: a sleeping shared domain overrides the channel state
    always_comb begin
        pd_o    = (st == CH_NAP) || hold_i;
        ready_o = (st == CH_RUN) && ref_ready_i;
    end

    // R3 / R9: a sampled nap bit powers the channel down on the next edge
    assert_nap_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nap_i |=> pd_o);
    // R4: the channel is never ready before the cycle count has finished
    assert_wake_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_WCYC && cyc != CYC_LAST) |=> !ready_o);
    // R5: during the settling wait, ready cannot appear without a tick
    assert_settle_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_WUS && !tick_i) |=> !ready_o);
    // R8: ready and power-down are never both set
    assert_ready_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !pd_o);
endmodule

// File: rtl/pwr_sleep_nap_ctrl.sv
// Sleep and nap power controller top.
// Merges the two sleep sources, shares one microsecond tick, and runs one
// nap sequencer per channel under the shared-domain sequencer.
// Assumes: all inputs are synchronous to clk.
module pwr_sleep_nap_ctrl #(
    parameter int NCH          = 2,
    parameter int DW           = 8,
    parameter int SW           = 16,
    parameter int NAP_CYC      = 100,
    parameter int SETTLE_US    = 50,
    parameter int DEF_SLEEP_US = 2000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep_bit_i,
    input  logic           par_mode_i,
    input  logic           sleep_pin_i,
    input  logic [NCH-1:0] nap_mask_i,
    input  logic           settle_req_i,
    input  logic [DW-1:0]  tick_div_i,
    input  logic [SW-1:0]  sleep_us_i,
    output logic           ref_pd_o,
    output logic [NCH-1:0] ch_pd_o,
    output logic [NCH-1:0] ch_ready_o,
    output logic           ref_ready_o
);
    logic sleep_req;
    logic us_tick;

    // Sleep source merge: the pin counts only in static-pin mode
    always_comb sleep_req = sleep_bit_i || (par_mode_i && sleep_pin_i);

    pwrseq_tick #(.DW(DW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (tick_div_i),
        .tick_o (us_tick)
    );

    pwrseq_ref #(.SW(SW), .DEF_US(DEF_SLEEP_US)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (sleep_req),
        .tick_i  (us_tick),
        .us_i    (sleep_us_i),
        .pd_o    (ref_pd_o),
        .ready_o (ref_ready_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwrseq_chan #(.NAP_CYC(NAP_CYC), .SETTLE_US(SETTLE_US)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .nap_i       (nap_mask_i[g]),
            .hold_i      (ref_pd_o),
            .settle_i    (settle_req_i),
            .tick_i      (us_tick),
            .ref_ready_i (ref_ready_o),
            .pd_o        (ch_pd_o[g]),
            .ready_o     (ch_ready_o[g])
        );
    end

    // R8: a sleeping shared domain forces every channel off and not ready
    assert_sleep_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pd_o |-> (&ch_pd_o && ch_ready_o == '0));
    // R2: with static-pin mode off and the register bit clear, no new sleep starts
    assert_pin_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode_i && !sleep_bit_i && !ref_pd_o) |=> !ref_pd_o);
endmodule

// File: tb/pwr_sleep_nap_ctrl_tb.sv
module pwr_sleep_nap_ctrl_tb;
    localparam int NCH = 2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_bit = 1'b0, par_mode = 1'b0, sleep_pin = 1'b0, settle = 1'b0;
    logic [NCH-1:0] nap = '0;
    logic [7:0]  div = 8'd4;
    logic [15:0] sus = 16'd10;
    logic ref_pd, ref_ready;
    logic [NCH-1:0] ch_pd, ch_ready;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    pwr_sleep_nap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_bit_i(sleep_bit), .par_mode_i(par_mode),
        .sleep_pin_i(sleep_pin), .nap_mask_i(nap), .settle_req_i(settle),
        .tick_div_i(div), .sleep_us_i(sus), .ref_pd_o(ref_pd), .ch_pd_o(ch_pd),
        .ch_ready_o(ch_ready), .ref_ready_o(ref_ready)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        step(1);
        check("R10 ref_pd", 32'(ref_pd), 0);
        check("R10 ch_pd", 32'(ch_pd), 0);
        check("R10 ch_ready", 32'(ch_ready), 3);
        check("R10 ref_ready", 32'(ref_ready), 1);
    endtask

    task automatic t_nap_basic;
        nap = 2'b01; settle = 1'b0;
        step(1);
        check("R3 ch_pd", 32'(ch_pd), 1);
        check("R3 ref_pd", 32'(ref_pd), 0);
        check("R3 ch_ready", 32'(ch_ready), 2);
        nap = 2'b00;
        step(1);
        check("R4 pd falls", 32'(ch_pd), 0);
        step(99);
        check("R4 not ready at 99", 32'(ch_ready[0]), 0);
        step(1);
        check("R4 ready at 100", 32'(ch_ready[0]), 1);
    endtask

    task automatic t_nap_settle;
        div = 8'd4; settle = 1'b1; nap = 2'b10;
        step(2);
        nap = 2'b00;
        step(1 + 100 + 196);
        check("R5 not ready during settle", 32'(ch_ready[1]), 0);
        step(6);
        check("R5 ready after settle", 32'(ch_ready[1]), 1);
        settle = 1'b0;
    endtask

    task automatic t_nap_abort;
        nap = 2'b01;
        step(2);
        nap = 2'b00;
        step(51);
        nap = 2'b01;
        step(1);
        check("R9 nap abort pd", 32'(ch_pd[0]), 1);
        nap = 2'b00;
        step(1 + 99);
        check("R9 nap restart full count", 32'(ch_ready[0]), 0);
        step(1);
        check("R9 nap ready after restart", 32'(ch_ready[0]), 1);
    endtask

    task automatic t_sleep_reg;
        div = 8'd4; sus = 16'd10; nap = 2'b00;
        sleep_bit = 1'b1;
        step(1);
        check("R1 ref_pd", 32'(ref_pd), 1);
        check("R8 all ch off", 32'(ch_pd), 3);
        check("R8 none ready", 32'(ch_ready), 0);
        sleep_bit = 1'b0;
        step(1);
        check("R7 leaves sleep", 32'(ref_pd), 0);
        step(36);
        check("R7 R6 not ready early", 32'(ref_ready), 0);
        step(6);
        check("R7 R6 ready after ticks", 32'(ref_ready), 1);
        check("R8 channels ready again", 32'(ch_ready), 3);
    endtask

    task automatic t_pin;
        par_mode = 1'b0; sleep_pin = 1'b1;
        step(3);
        check("R2 pin ignored pd", 32'(ref_pd), 0);
        check("R2 pin ignored ready", 32'(ref_ready), 1);
        par_mode = 1'b1;
        step(1);
        check("R2 pin sleeps", 32'(ref_pd), 1);
        sleep_pin = 1'b0;
        step(1);
        step(20);
        sleep_pin = 1'b1;
        step(1);
        check("R9 sleep abort", 32'(ref_pd), 1);
        sleep_pin = 1'b0; par_mode = 1'b0;
        step(1);
        step(36);
        check("R9 sleep restart full wait", 32'(ref_ready), 0);
        step(6);
        check("R9 ready after restart", 32'(ref_ready), 1);
    endtask

    task automatic t_default;
        div = 8'd0; sus = 16'd0;
        sleep_bit = 1'b1;
        step(1);
        sleep_bit = 1'b0;
        step(1);
        step(1995);
        check("R7 R6 default not ready", 32'(ref_ready), 0);
        step(8);
        check("R7 R6 default ready", 32'(ref_ready), 1);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_nap_basic();
        t_nap_settle();
        t_nap_abort();
        t_sleep_reg();
        t_pin();
        t_default();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule